// File: doc/BRIEF.md
# PCI DMA Window Address Translator

This block sits between PCI bus-master traffic and system memory. It turns a PCI DMA address into a system address using four programmable windows. Each window compares the upper bits of the incoming address against a base value, with a programmable mask. A window that hits either maps the address straight through with a new upper part (direct-mapped), or fetches a 64-bit page table entry from memory and builds the system page from that entry (scatter-gather).

Single-cycle addresses are those below 4 GiB. They can be blocked by a hole at 512 KiB–1 MiB, and they are matched against the windows in fixed priority order. Dual-cycle addresses take one of two paths: a control-enabled bypass range that maps straight through, or a scatter-gather path through the last window when that window has its dual-cycle enable set. Software programs the windows through a simple register port. Requests enter through a valid/ready port, and one translation is handled at a time. A miss, or a page table entry without its valid bit, returns a fault.

Top module: `dma_win_xlat`

## Requirements
- R1: Register writes keep only their defined bits. Base registers (index 0–2) keep mask 0xFFF0_0003, where bit 0 is the enable and bit 1 is scatter-gather. Mask registers (index 4–7) keep 0xFFF0_0000. Translated-base registers (index 8–11) keep 0x7_FFFF_FC00. The control register (index 12) keeps bit 5 (hole) and bit 6 (dual-cycle bypass). Reads return the stored value.
- R2: Base register 3 keeps mask 0x80_FFF0_0001, where bit 39 is the dual-cycle enable. Bit 1 (scatter-gather) of this register always reads 1.
- R3: A single-cycle window hits only when it is enabled and the address bits [31:20] with the mask bits cleared equal base bits [31:20]. A disabled window never hits.
- R4: A direct-mapped hit returns (translated base AND NOT ext) OR (address AND ext), where ext = mask OR 0xFFFFF. No memory read is made.
- R5: A scatter-gather hit reads the entry at address (translated base AND NOT (mask>>10)) OR ((address AND (mask OR 0xFE000))>>10). The result is entry bits [21:1] placed at bit 13 and up, with address bits [12:0] below them.
- R6: An entry whose bit 0 is clear gives a fault response with address 0.
- R7: When control bit 5 is set, single-cycle addresses from 0x80000 to 0xFFFFF fault, whatever the windows hold.
- R8: Windows 0, 1 and 2 are tried in that order, and the lowest hit wins. Window 3 is tried last, and only when its dual-cycle enable is clear.
- R9: When control bit 6 is set, addresses from 0x100_0000_0000 to 0x1FF_FFFF_FFFF return their low 35 bits with no memory read. When bit 6 is clear, these addresses fault.
- R10: Addresses from 0x800_0000_0000 to 0xFFF_FFFF_FFFF go through window 3 when it is enabled with its dual-cycle enable set. The entry address is (translated base AND 0x7_FFC0_0000) OR ((address AND 0xFFFF_E000)>>10). In all other cases these addresses fault.
- R11: Any address that no path accepts gives a fault with address 0 and no memory read.
- R12: Only one request is in flight. req_ready stays low from acceptance until the response is taken. A response stays valid and stable until rsp_ready is high.
- R13: A translation uses the register values from the cycle in which the request is accepted. A register write in that same cycle affects only later requests.
- R14: After reset, windows 0–2 are disabled, base register 3 reads 0x2, all other registers read 0, req_ready is 1 and rsp_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | 4 | Register index (0–3 base, 4–7 mask, 8–11 translated base, 12 control) |
| csr_wdata | input | 64 | Register write data |
| csr_rdata | output | 64 | Read data for csr_addr |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Ready to accept a request |
| req_addr | input | 44 | PCI DMA address |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed |
| rsp_addr | output | 35 | Translated system address (0 on fault) |
| rsp_fault | output | 1 | Translation failed |
| mem_req | output | 1 | Page table entry read request, held until mem_rvalid |
| mem_addr | output | 35 | Page table entry address |
| mem_rvalid | input | 1 | Entry data valid |
| mem_rdata | input | 64 | Entry data |

## Verification
A register write and a request acceptance can fall in the same clock cycle, and the window being rewritten may be the one that decodes the request. The bench provokes this by raising csr_wr and req_valid on the same edge: it disables window 2 while requesting an address that window 2 maps. It expects window 2's direct result for that request. A second request to the same address must then fall through to window 3's scatter-gather path. A stale decode or a premature update shows up as the wrong one of the two results.

// File: rtl/dwx_pkg.sv
package dwx_pkg;

   localparam int NWIN = 4;

   // register index map
   localparam int IDX_BASE  = 0;
   localparam int IDX_MASK  = 4;
   localparam int IDX_TBASE = 8;
   localparam int IDX_CTRL  = 12;

   // write-keep masks
   localparam logic [63:0] KEEP_BASE      = 64'h0000_0000_FFF0_0003;
   localparam logic [63:0] KEEP_BASE_LAST = 64'h0000_0080_FFF0_0001;
   localparam logic [63:0] KEEP_MASK      = 64'h0000_0000_FFF0_0000;
   localparam logic [63:0] KEEP_TBASE     = 64'h0000_0007_FFFF_FC00;
   localparam logic [63:0] KEEP_DAC_TBASE = 64'h0000_0007_FFC0_0000;

   localparam int BIT_EN     = 0;
   localparam int BIT_SG     = 1;
   localparam int BIT_DAC    = 39;
   localparam int BIT_HOLE   = 5;
   localparam int BIT_BYPASS = 6;

   typedef enum logic [1:0] {
      XK_FAULT  = 2'd0,
      XK_DIRECT = 2'd1,
      XK_FETCH  = 2'd2
   } xkind_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_RESP  = 2'd2
   } xstate_e;

endpackage

// File: rtl/dwx_regs.sv
module dwx_regs
   import dwx_pkg::*;
#(
   parameter int BASE_W = 40,
   parameter int SYS_W  = 35
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         csr_wr,
   input  logic [3:0]                   csr_addr,
   input  logic [63:0]                  csr_wdata,
   output logic [63:0]                  csr_rdata,
   output logic [NWIN-1:0][BASE_W-1:0]  base_o,
   output logic [NWIN-1:0][31:0]        mask_o,
   output logic [NWIN-1:0][SYS_W-1:0]   tba_o,
   output logic                         hole_o,
   output logic                         bypass_o
);

   for (genvar g = 0; g < NWIN; g++) begin : g_win
      localparam logic [3:0] A_BASE  = 4'(IDX_BASE + g);
      localparam logic [3:0] A_MASK  = 4'(IDX_MASK + g);
      localparam logic [3:0] A_TBASE = 4'(IDX_TBASE + g);
      localparam logic [63:0] KEEP   = (g == NWIN - 1) ? KEEP_BASE_LAST : KEEP_BASE;
      localparam logic [BASE_W-1:0] FORCE =
         (g == NWIN - 1) ? BASE_W'(1 << BIT_SG) : '0;

      logic [BASE_W-1:0] base_q;
      logic [31:0]       mask_q;
      logic [SYS_W-1:0]  tba_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_q <= FORCE;
            mask_q <= '0;
            tba_q  <= '0;
         end else if (csr_wr) begin
            if (csr_addr == A_BASE)
               base_q <= (csr_wdata[BASE_W-1:0] & KEEP[BASE_W-1:0]) | FORCE;
            if (csr_addr == A_MASK)
               mask_q <= csr_wdata[31:0] & KEEP_MASK[31:0];
            if (csr_addr == A_TBASE)
               tba_q <= csr_wdata[SYS_W-1:0] & KEEP_TBASE[SYS_W-1:0];
         end
      end

      assign base_o[g] = base_q;
      assign mask_o[g] = mask_q;
      assign tba_o[g]  = tba_q;
   end

   logic hole_q, bypass_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hole_q   <= 1'b0;
         bypass_q <= 1'b0;
      end else if (csr_wr && csr_addr == 4'(IDX_CTRL)) begin
         hole_q   <= csr_wdata[BIT_HOLE];
         bypass_q <= csr_wdata[BIT_BYPASS];
      end
   end
   assign hole_o   = hole_q;
   assign bypass_o = bypass_q;

   logic [63:40] unused_wdata;
   assign unused_wdata = csr_wdata[63:40];

   always_comb begin
      csr_rdata = '0;
      if (csr_addr < 4'(IDX_MASK))
         csr_rdata = 64'(base_o[csr_addr[1:0]]);
      else if (csr_addr < 4'(IDX_TBASE))
         csr_rdata = 64'(mask_o[csr_addr[1:0]]);
      else if (csr_addr < 4'(IDX_CTRL))
         csr_rdata = 64'(tba_o[csr_addr[1:0]]);
      else if (csr_addr == 4'(IDX_CTRL)) begin
         csr_rdata[BIT_HOLE]   = hole_q;
         csr_rdata[BIT_BYPASS] = bypass_q;
      end
   end

endmodule

// File: rtl/dwx_decode.sv
module dwx_decode
   import dwx_pkg::*;
#(
   parameter int ADDR_W = 44,
   parameter int BASE_W = 40,
   parameter int SYS_W  = 35
) (
   input  logic [ADDR_W-1:0]            addr,
   input  logic [NWIN-1:0][BASE_W-1:0]  base,
   input  logic [NWIN-1:0][31:0]        mask,
   input  logic [NWIN-1:0][SYS_W-1:0]   tba,
   input  logic                         hole_en,
   input  logic                         bypass_en,
   output xkind_e                       kind,
   output logic [SYS_W-1:0]             res_addr,
   output logic [SYS_W-1:0]             pte_addr
);

   localparam int PAD32 = SYS_W - 32;
   localparam int PAD22 = SYS_W - 22;

   logic single;
   logic in_hole;
   logic bypass_hit;
   logic dac_hit;
   logic [SYS_W-1:0] dac_pte;
   logic [SYS_W-1:0] addr_lo;

   assign single  = (addr[ADDR_W-1:32] == '0);
   assign addr_lo = {{PAD32{1'b0}}, addr[31:0]};
   assign in_hole = hole_en && single &&
                    (addr[31:0] >= 32'h0008_0000) && (addr[31:0] <= 32'h000F_FFFF);

   logic [NWIN-1:0]            hit;
   logic [NWIN-1:0]            is_sg;
   logic [NWIN-1:0][SYS_W-1:0] dir_res;
   logic [NWIN-1:0][SYS_W-1:0] sg_pte;

   for (genvar g = 0; g < NWIN; g++) begin : g_match
      logic [SYS_W-1:0] ext;
      logic [SYS_W-1:0] mshift;
      logic [31:0]      am;
      logic             usable;

      assign ext    = {{PAD32{1'b0}}, mask[g][31:20], 20'hF_FFFF};
      assign mshift = {{PAD22{1'b0}}, mask[g][31:20], 10'b0};
      assign am     = addr[31:0] & (mask[g] | 32'h000F_E000);

      if (g == NWIN - 1) begin : g_last
         assign usable = !base[g][BIT_DAC];
      end else begin : g_plain
         assign usable = 1'b1;
      end

      assign hit[g] = usable && base[g][BIT_EN] &&
                      ((addr[31:20] & ~mask[g][31:20]) == base[g][31:20]);
      assign is_sg[g]   = base[g][BIT_SG];
      assign dir_res[g] = (tba[g] & ~ext) | (addr_lo & ext);
      assign sg_pte[g]  = (tba[g] & ~mshift) | {{PAD22{1'b0}}, am[31:10]};
   end

   assign bypass_hit = bypass_en && (addr[ADDR_W-1:40] == 4'h1);
   assign dac_hit    = addr[ADDR_W-1] && base[NWIN-1][BIT_EN] && base[NWIN-1][BIT_DAC];
   assign dac_pte    = (tba[NWIN-1] & KEEP_DAC_TBASE[SYS_W-1:0]) |
                       {{PAD22{1'b0}}, addr[31:13], 3'b0};

   always_comb begin
      logic found;
      found    = 1'b0;
      kind     = XK_FAULT;
      res_addr = '0;
      pte_addr = '0;
      if (single) begin
         if (!in_hole) begin
            for (int w = 0; w < NWIN; w++) begin
               if (!found && hit[w]) begin
                  found = 1'b1;
                  if (is_sg[w]) begin
                     kind     = XK_FETCH;
                     pte_addr = sg_pte[w];
                  end else begin
                     kind     = XK_DIRECT;
                     res_addr = dir_res[w];
                  end
               end
            end
         end
      end else if (bypass_hit) begin
         kind     = XK_DIRECT;
         res_addr = addr[SYS_W-1:0];
      end else if (dac_hit) begin
         kind     = XK_FETCH;
         pte_addr = dac_pte;
      end
   end

   logic unused_fields;
   assign unused_fields = ^{mask[0][19:0], mask[1][19:0], mask[2][19:0], mask[3][19:0],
                            base[0][19:2], base[1][19:2], base[2][19:2], base[3][19:2],
                            base[0][BASE_W-1:32], base[1][BASE_W-1:32],
                            base[2][BASE_W-1:32], base[3][38:32]};

endmodule

// File: rtl/dwx_ctrl.sv
module dwx_ctrl
   import dwx_pkg::*;
#(
   parameter int SYS_W = 35
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [12:0]      req_lo,
   input  xkind_e           kind,
   input  logic [SYS_W-1:0] res_addr,
   input  logic [SYS_W-1:0] pte_addr,
   output logic             rsp_valid,
   input  logic             rsp_ready,
   output logic [SYS_W-1:0] rsp_addr,
   output logic             rsp_fault,
   output logic             mem_req,
   output logic [SYS_W-1:0] mem_addr,
   input  logic             mem_rvalid,
   input  logic [63:0]      mem_rdata
);

   xstate_e          state_q;
   logic [12:0]      lo_q;
   logic [SYS_W-1:0] mem_addr_q;
   logic [SYS_W-1:0] out_q;
   logic             fault_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         lo_q       <= '0;
         mem_addr_q <= '0;
         out_q      <= '0;
         fault_q    <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (req_valid) begin
               lo_q <= req_lo;
               unique case (kind)
                  XK_DIRECT: begin
                     out_q   <= res_addr;
                     fault_q <= 1'b0;
                     state_q <= ST_RESP;
                  end
                  XK_FETCH: begin
                     mem_addr_q <= pte_addr;
                     state_q    <= ST_FETCH;
                  end
                  default: begin
                     out_q   <= '0;
                     fault_q <= 1'b1;
                     state_q <= ST_RESP;
                  end
               endcase
            end
            ST_FETCH: if (mem_rvalid) begin
               fault_q <= !mem_rdata[0];
               out_q   <= mem_rdata[0] ?
                          {{(SYS_W-34){1'b0}}, mem_rdata[21:1], lo_q} : '0;
               state_q <= ST_RESP;
            end
            ST_RESP: if (rsp_ready) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (state_q == ST_IDLE);
   assign mem_req   = (state_q == ST_FETCH);
   assign rsp_valid = (state_q == ST_RESP);
   assign mem_addr  = mem_addr_q;
   assign rsp_addr  = out_q;
   assign rsp_fault = fault_q;

   logic [63:22] unused_pte;
   assign unused_pte = mem_rdata[63:22];

endmodule

// File: rtl/dma_win_xlat.sv
module dma_win_xlat
   import dwx_pkg::*;
#(
   parameter int ADDR_W = 44,
   parameter int SYS_W  = 35
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csr_wr,
   input  logic [3:0]        csr_addr,
   input  logic [63:0]       csr_wdata,
   output logic [63:0]       csr_rdata,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [SYS_W-1:0]  rsp_addr,
   output logic              rsp_fault,
   output logic              mem_req,
   output logic [SYS_W-1:0]  mem_addr,
   input  logic              mem_rvalid,
   input  logic [63:0]       mem_rdata
);

   localparam int BASE_W = BIT_DAC + 1;

   if (ADDR_W != 44) begin : g_bad_addr_w
      $error("dma_win_xlat: ADDR_W must be 44");
   end
   if (SYS_W < 35 || SYS_W > 64) begin : g_bad_sys_w
      $error("dma_win_xlat: SYS_W must lie in 35..64");
   end

   logic [NWIN-1:0][BASE_W-1:0] base;
   logic [NWIN-1:0][31:0]       mask;
   logic [NWIN-1:0][SYS_W-1:0]  tba;
   logic                        hole_en, bypass_en;
   xkind_e                      kind;
   logic [SYS_W-1:0]            res_addr, pte_addr;

   dwx_regs #(.BASE_W(BASE_W), .SYS_W(SYS_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_addr(csr_addr),
      .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .base_o(base),
      .mask_o(mask), .tba_o(tba), .hole_o(hole_en), .bypass_o(bypass_en)
   );

   dwx_decode #(.ADDR_W(ADDR_W), .BASE_W(BASE_W), .SYS_W(SYS_W)) u_dec (
      .addr(req_addr), .base(base), .mask(mask), .tba(tba),
      .hole_en(hole_en), .bypass_en(bypass_en), .kind(kind),
      .res_addr(res_addr), .pte_addr(pte_addr)
   );

   dwx_ctrl #(.SYS_W(SYS_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_lo(req_addr[12:0]), .kind(kind), .res_addr(res_addr),
      .pte_addr(pte_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
      .rsp_addr(rsp_addr), .rsp_fault(rsp_fault), .mem_req(mem_req),
      .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
   );

endmodule

// File: rtl/dwx_checker.sv
module dwx_checker #(
   parameter int SYS_W = 35
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic             rsp_valid,
   input logic             rsp_ready,
   input logic [SYS_W-1:0] rsp_addr,
   input logic             rsp_fault,
   input logic             mem_req,
   input logic [SYS_W-1:0] mem_addr,
   input logic             mem_rvalid
);

   AST_BUSY_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !req_ready);  // R12

   AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_fault));  // R12

   AST_ACCEPT_THEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready);  // R12

   AST_FETCH_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !rsp_valid && !req_ready);  // R5

   AST_FETCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr));  // R5

   AST_PTE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> mem_addr[2:0] == 3'b000);  // R5

   AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_fault |-> rsp_addr == '0);  // R11

endmodule

bind dma_win_xlat dwx_checker #(.SYS_W(SYS_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
   .rsp_fault(rsp_fault), .mem_req(mem_req), .mem_addr(mem_addr),
   .mem_rvalid(mem_rvalid)
);

// File: tb/dma_win_xlat_bench.sv
module dma_win_xlat_bench;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        csr_wr = 1'b0;
   logic [3:0]  csr_addr = '0;
   logic [63:0] csr_wdata = '0;
   logic [63:0] csr_rdata;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [43:0] req_addr = '0;
   logic        rsp_valid;
   logic        rsp_ready = 1'b1;
   logic [34:0] rsp_addr;
   logic        rsp_fault;
   logic        mem_req;
   logic [34:0] mem_addr;
   logic        mem_rvalid = 1'b0;
   logic [63:0] mem_rdata = '0;

   int n_chk = 0;
   int n_fail = 0;
   int cycles = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dma_win_xlat u_dma_win_xlat (
      .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_addr(csr_addr),
      .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .req_valid(req_valid),
      .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid),
      .rsp_ready(rsp_ready), .rsp_addr(rsp_addr), .rsp_fault(rsp_fault),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
      .mem_rdata(mem_rdata)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles == WATCHDOG) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: act=%0d cycles exp=<%0d", cycles, WATCHDOG);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [63:0] d);
      @(negedge clk);
      csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
      @(negedge clk);
      csr_wr = 1'b0;
   endtask

   task automatic rd_check(input logic [3:0] a, input logic [63:0] exp, input string req);
      @(negedge clk);
      csr_addr = a;
      #1;
      check(csr_rdata == exp, req, csr_rdata, exp);
   endtask

   // wait for outcome of an already accepted request; serves entry reads
   task automatic finish_xlat(input logic [63:0] pte, input bit exp_fetch,
                              input logic [34:0] exp_pa, input bit exp_fault,
                              input logic [34:0] exp_out, input string req);
      bit fetched = 1'b0;
      bit done = 1'b0;
      for (int i = 0; i < 40 && !done; i++) begin
         mem_rvalid = 1'b0;
         if (rsp_valid) begin
            check(rsp_fault == exp_fault, {req, " fault"}, 64'(rsp_fault), 64'(exp_fault));
            check(rsp_addr == exp_out, {req, " addr"}, 64'(rsp_addr), 64'(exp_out));
            done = 1'b1;
         end else begin
            if (mem_req) begin
               check(mem_addr == exp_pa, {req, " entry addr"}, 64'(mem_addr), 64'(exp_pa));
               fetched = 1'b1;
               mem_rvalid = 1'b1;
               mem_rdata = pte;
            end
            @(negedge clk);
         end
      end
      check(fetched == exp_fetch, {req, " fetch made"}, 64'(fetched), 64'(exp_fetch));
      check(done, {req, " response seen"}, 64'(done), 64'd1);
      @(negedge clk);
   endtask

   task automatic xlat(input logic [43:0] a, input logic [63:0] pte, input bit exp_fetch,
                       input logic [34:0] exp_pa, input bit exp_fault,
                       input logic [34:0] exp_out, input string req);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a;
      @(negedge clk);
      req_valid = 1'b0;
      finish_xlat(pte, exp_fetch, exp_pa, exp_fault, exp_out, req);
   endtask

   typedef struct packed {
      logic [43:0] addr;
      logic [63:0] pte;
      logic        fetch;
      logic [34:0] pa;
      logic        fault;
      logic [34:0] out;
   } vec_t;

   localparam int NVEC = 10;
   localparam vec_t VEC [NVEC] = '{
      '{44'h0_1012_3456, 64'h0,      1'b0, 35'h0,           1'b0, 35'h2_0012_3456}, // R4 W0 direct
      '{44'h0_2008_A5F8, 64'h246A8B, 1'b1, 35'h1_2345_6E28, 1'b0, 35'h2_46A8_A5F8}, // R5 W1 SG
      '{44'h0_2000_0008, 64'h246A8A, 1'b1, 35'h1_2345_6C00, 1'b1, 35'h0},           // R6 invalid entry
      '{44'h0_3012_3456, 64'h0,      1'b0, 35'h0,           1'b0, 35'h5_4012_3456}, // R8 W2 over W3
      '{44'h0_30AB_CDEF, 64'h0,      1'b0, 35'h0,           1'b0, 35'h5_40AB_CDEF}, // R4 W2 direct
      '{44'h0_5000_0000, 64'h0,      1'b0, 35'h0,           1'b1, 35'h0},           // R11 miss
      '{44'h1_0000_0000, 64'h0,      1'b0, 35'h0,           1'b1, 35'h0},           // R11 above 4G
      '{44'h123_4567_89AB, 64'h0,    1'b0, 35'h0,           1'b1, 35'h0},           // R9 bypass off
      '{44'h8AB_CDEF_2345, 64'h0,    1'b0, 35'h0,           1'b1, 35'h0},           // R10 DAC off
      '{44'h0_10FF_FFFF, 64'h0,      1'b0, 35'h0,           1'b0, 35'h2_00FF_FFFF}  // R3 mask edge
   };

   initial begin
      // R14 reset state
      #(CLK_PERIOD * 2 + 1);
      check(req_ready == 1'b1, "R14 req_ready", 64'(req_ready), 64'd1);
      check(rsp_valid == 1'b0, "R14 rsp_valid", 64'(rsp_valid), 64'd0);
      rd_check(4'd0, 64'h0, "R14 base0");
      rd_check(4'd3, 64'h2, "R14 base3");
      rd_check(4'd12, 64'h0, "R14 control");
      rst_n = 1'b1;

      // R1 / R2 write-keep masks
      wr(4'd1, '1);  rd_check(4'd1, 64'hFFF0_0003, "R1 base keep");
      wr(4'd5, '1);  rd_check(4'd5, 64'hFFF0_0000, "R1 mask keep");
      wr(4'd9, '1);  rd_check(4'd9, 64'h7_FFFF_FC00, "R1 tbase keep");
      wr(4'd12, '1); rd_check(4'd12, 64'h60, "R1 control keep");
      wr(4'd3, '1);  rd_check(4'd3, 64'h80_FFF0_0003, "R2 base3 keep");
      wr(4'd3, 64'h0); rd_check(4'd3, 64'h2, "R2 base3 sg forced");
      wr(4'd12, 64'h0);

      // configuration for table
      wr(4'd0, 64'h1000_0001); wr(4'd4, 64'h00F0_0000); wr(4'd8,  64'h2_0000_0000);
      wr(4'd1, 64'h2000_0003); wr(4'd5, 64'h0);         wr(4'd9,  64'h1_2345_6C00);
      wr(4'd2, 64'h3000_0001); wr(4'd6, 64'h00F0_0000); wr(4'd10, 64'h5_4000_0000);
      wr(4'd3, 64'h3010_0001); wr(4'd7, 64'h0);         wr(4'd11, 64'h0_8000_0000);

      for (int v = 0; v < NVEC; v++)
         xlat(VEC[v].addr, VEC[v].pte, VEC[v].fetch, VEC[v].pa, VEC[v].fault, VEC[v].out,
              $sformatf("R3-R11 vector %0d", v));
      xlat(44'h0_1100_0000, 64'h0, 1'b0, 35'h0, 1'b1, 35'h0, "R3 outside masked base");

      // R13 write in the accept cycle disables W2: old decode applies
      @(negedge clk);
      req_valid = 1'b1; req_addr = 44'h0_3012_3456;
      csr_wr = 1'b1; csr_addr = 4'd2; csr_wdata = 64'h3000_0000;
      @(negedge clk);
      req_valid = 1'b0; csr_wr = 1'b0;
      finish_xlat(64'h0, 1'b0, 35'h0, 1'b0, 35'h5_4012_3456, "R13 same-cycle write");
      // R3 / R8 W2 now disabled, W3 SG takes it
      xlat(44'h0_3012_3456, 64'hAB1, 1'b1, 35'h0_8000_0088, 1'b0, 35'h0_00AB_1456,
           "R8 falls to window 3");

      // R12 response held while rsp_ready low
      rsp_ready = 1'b0;
      @(negedge clk);
      req_valid = 1'b1; req_addr = 44'h0_1000_0040;
      @(negedge clk);
      req_valid = 1'b0;
      for (int i = 0; i < 3; i++) begin
         check(rsp_valid && !req_ready, "R12 held busy", {62'b0, rsp_valid, req_ready}, 64'h2);
         check(rsp_addr == 35'h2_0000_0040, "R12 held addr", 64'(rsp_addr), 64'h2_0000_0040);
         @(negedge clk);
      end
      rsp_ready = 1'b1;
      @(negedge clk);
      check(req_ready && !rsp_valid, "R12 released", {62'b0, rsp_valid, req_ready}, 64'h1);

      // R9 bypass
      wr(4'd12, 64'h40);
      xlat(44'h123_4567_89AB, 64'h0, 1'b0, 35'h0, 1'b0, 35'h3_4567_89AB, "R9 bypass on");
      xlat(44'h200_0000_0000, 64'h0, 1'b0, 35'h0, 1'b1, 35'h0, "R9 above bypass");

      // R10 dual-cycle through window 3
      wr(4'd3, 64'h80_4000_0001); wr(4'd11, 64'h3_FFFF_FC00);
      xlat(44'h8AB_CDEF_2345, 64'h3, 1'b1, 35'h3_FFF3_7BC8, 1'b0, 35'h0_0000_2345, "R10 DAC SG");
      // R8 window 3 ignored for single-cycle when DAC bit set
      xlat(44'h0_4000_1000, 64'h1, 1'b0, 35'h0, 1'b1, 35'h0, "R8 window 3 DAC gated");

      // R7 hole
      wr(4'd0, 64'h1); wr(4'd4, 64'h0); wr(4'd8, 64'h1_0000_0000); wr(4'd12, 64'h0);
      xlat(44'h0_0009_0000, 64'h0, 1'b0, 35'h0, 1'b0, 35'h1_0009_0000, "R7 hole off");
      wr(4'd12, 64'h20);
      xlat(44'h0_0009_0000, 64'h0, 1'b0, 35'h0, 1'b1, 35'h0, "R7 hole inside");
      xlat(44'h0_0008_0000, 64'h0, 1'b0, 35'h0, 1'b1, 35'h0, "R7 hole low edge");
      xlat(44'h0_000F_FFFF, 64'h0, 1'b0, 35'h0, 1'b1, 35'h0, "R7 hole high edge");
      xlat(44'h0_0007_FFF8, 64'h0, 1'b0, 35'h0, 1'b0, 35'h1_0007_FFF8, "R7 below hole");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule